// File: doc/BRIEF.md
# Serial Port Control Register Bank with Atomic Bit Aliases

This block is the software-visible control store of a serial port. It holds four 32-bit registers on a simple single-cycle read/write bus: a reset/gating register, a port-control register, a line-control word and an interrupt register. Every register occupies a 16-byte slot. Writes to the slot's base offset replace the value. Writes to the next three words OR bits in, clear bits, or XOR bits. Software can therefore change a single field without a read-modify-write sequence.

The reset/gating register is managed by a small sequencer. After power-on the port is held in soft reset with its clock gated. Clearing the soft-reset bit does not take effect at once. The bit keeps reading 1 for a settle period, and the clock gate cannot be opened until that period has ended. The sequencer states are `ST_RESET`, `ST_SETTLE`, `ST_GATED` and `ST_RUN`. Its transitions are:
- **release**: `ST_RESET` to `ST_SETTLE`.
- **settled**: `ST_SETTLE` to `ST_GATED`, when the counter expires.
- **ungate**: `ST_GATED` to `ST_RUN`.
- **regate**: `ST_RUN` to `ST_GATED`.
- **re-reset**: any state to `ST_RESET`, whenever a write leaves the soft-reset bit at 1.

The interrupt register pairs four status flags with four enables. Status flags are raised by one-cycle event pulses from the serial datapath. The enabled flags are combined onto a single interrupt line.

Top module: `sct_regbank`

## Requirements
- R1: After reset, offset 0x00 reads 0xC000_0000, and offsets 0x10, 0x20 and 0x30 read 0. `srst_o` and `clk_gate_o` are 1, and `irq_o` is 0.
- R2: The register index is address bits [ADDR_W-1:4] (0 = reset/gating, 1 = port control, 2 = line control, 3 = interrupt). Address bits [3:2] select the write operation: 0 replaces the value, 1 ORs the data in, 2 clears the bits set in the data, and 3 XORs the data in. The updated value is visible on the next cycle.
- R3: A read at any of the four words of a slot returns that register's current value. A read of an index of 4 or above returns 0.
- R4: In the port-control register only bits 15 (CTS flow enable), 14 (RTS flow enable), 11 (RTS), 9 (receive enable), 8 (transmit enable) and 0 (port enable) are writable; all other bits read 0. Each of these bits drives its own output.
- R5: While in soft reset, bit 31 of offset 0x00 reads 1. After a write leaves bit 31 at 0, the bit keeps reading 1 for exactly SETTLE_CYC cycles and then reads 0. In `ST_SETTLE`, any ctrl0 write that leaves bit 31 at 1 restarts the reset.
- R6: Bit 30 is the clock gate (`clk_gate_o`). Writes that clear it are ignored while bit 31 reads 1. Once bit 31 reads 0, clearing bit 30 opens the gate, and setting bit 30 closes it again without disturbing the other registers.
- R7: The cycle a write leaves bit 31 at 1, and for as long as bit 31 reads 1, the other three registers return to 0. Bus writes and event pulses are ignored during this time.
- R8: Interrupt enables are bits 22 (receive timeout), 21 (transmit), 20 (receive) and 17 (modem CTS change). The matching status flags are bits 6, 5, 4 and 1. A pulse on `evt_i[3]`, `evt_i[2]`, `evt_i[1]` or `evt_i[0]` sets status bit 6, 5, 4 or 1 respectively.
- R9: A status flag is cleared by writing 1 to it through the clear alias (offset 0x38). If an event pulse for the same flag arrives in the same cycle, the flag stays set.
- R10: `irq_o` is 1 exactly when some status flag and its enable (the bit 16 positions above it) are both 1.
- R11: Bits 29:0 of offset 0x00 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| evt_i | input | 4 | Event pulses: [3] rx timeout, [2] tx, [1] rx, [0] CTS change |
| srst_o | output | 1 | Soft reset held |
| clk_gate_o | output | 1 | Port clock gated |
| cts_flow_en_o | output | 1 | CTS flow control enable |
| rts_flow_en_o | output | 1 | RTS flow control enable |
| rts_o | output | 1 | RTS level |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| port_en_o | output | 1 | Port enable |
| line_ctrl_o | output | 32 | Line-control word |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with ADDR_W = 8 and SETTLE_CYC = 5. The 8-bit address reaches the unmapped index 4, so the zero readback can be checked. A settle period of five cycles is long enough that an off-by-one in the sequencer counter changes the measured count, yet short enough to be counted sample by sample.

// File: rtl/sct_regbank_pkg.sv
package sct_regbank_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_REGS = 4;
    localparam int NUM_EVT  = 4;

    localparam int IDX_CTRL0 = 0;
    localparam int IDX_PORT  = 1;
    localparam int IDX_LINE  = 2;
    localparam int IDX_IRQ   = 3;

    localparam int SRST_BIT = 31;
    localparam int GATE_BIT = 30;

    localparam int PB_CTSF = 15;
    localparam int PB_RTSF = 14;
    localparam int PB_RTS  = 11;
    localparam int PB_RXEN = 9;
    localparam int PB_TXEN = 8;
    localparam int PB_PEN  = 0;

    localparam logic [REG_W-1:0] PORT_MASK = (REG_W'(1) << PB_CTSF) | (REG_W'(1) << PB_RTSF)
                                           | (REG_W'(1) << PB_RTS)  | (REG_W'(1) << PB_RXEN)
                                           | (REG_W'(1) << PB_TXEN) | (REG_W'(1) << PB_PEN);
    localparam logic [REG_W-1:0] LINE_MASK = '1;

    localparam int IRQ_EN_SHIFT = 16;
    localparam logic [REG_W-1:0] IRQ_STAT_MASK = 32'h0000_0072;
    localparam logic [REG_W-1:0] IRQ_EN_MASK   = IRQ_STAT_MASK << IRQ_EN_SHIFT;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GATED  = 2'd2,
        ST_RUN    = 2'd3
    } rst_state_e;

    function automatic logic [REG_W-1:0] apply_op(alias_op_e op, logic [REG_W-1:0] cur,
                                                  logic [REG_W-1:0] wd);
        logic [REG_W-1:0] r;
        unique case (op)
            OP_WRITE: r = wd;
            OP_SET:   r = cur | wd;
            OP_CLR:   r = cur & ~wd;
            OP_TOG:   r = cur ^ wd;
            default:  r = cur;
        endcase
        return r;
    endfunction

    // evt[3]->bit 6, evt[2]->bit 5, evt[1]->bit 4, evt[0]->bit 1
    function automatic logic [REG_W-1:0] event_vec(logic [NUM_EVT-1:0] evt);
        logic [REG_W-1:0] r;
        r = '0;
        r[6] = evt[3];
        r[5] = evt[2];
        r[4] = evt[1];
        r[1] = evt[0];
        return r;
    endfunction

endpackage

// File: rtl/sct_alias_reg.sv
module sct_alias_reg
    import sct_regbank_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK    = '1,
    parameter logic [REG_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             wr_en,
    input  alias_op_e        op,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    logic [REG_W-1:0] q_r;
    logic [REG_W-1:0] q_d;

    always_comb begin
        q_d = q_r;
        if (wr_en) begin
            q_d = (apply_op(op, q_r, wdata) & MASK) | (RST_VAL & ~MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= RST_VAL;
        end else if (hold) begin
            q_r <= RST_VAL;
        end else begin
            q_r <= q_d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/sct_rst_fsm.sv
module sct_rst_fsm
    import sct_regbank_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  alias_op_e  op,
    input  logic [1:0] wbits,   // [1] soft reset, [0] clock gate
    output logic       srst_o,
    output logic       gate_o,
    output logic       hold_o
);

    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    rst_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       cur;
    logic [1:0]       req;

    // Readback value of the two control bits and the result of the pending write
    always_comb begin
        cur = {(st_q == ST_RESET) || (st_q == ST_SETTLE), st_q != ST_RUN};
        unique case (op)
            OP_WRITE: req = wbits;
            OP_SET:   req = cur | wbits;
            OP_CLR:   req = cur & ~wbits;
            OP_TOG:   req = cur ^ wbits;
            default:  req = cur;
        endcase
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RESET: begin
                if (wr_en && !req[1]) begin          // release
                    st_d  = ST_SETTLE;
                    cnt_d = CNT_LOAD;
                end
            end
            ST_SETTLE: begin
                if (wr_en && req[1]) begin           // re-reset
                    st_d = ST_RESET;
                end else if (cnt_q == '0) begin      // settled
                    st_d = ST_GATED;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GATED: begin
                if (wr_en && req[1]) begin           // re-reset
                    st_d = ST_RESET;
                end else if (wr_en && !req[0]) begin // ungate
                    st_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (wr_en && req[1]) begin           // re-reset
                    st_d = ST_RESET;
                end else if (wr_en && req[0]) begin  // regate
                    st_d = ST_GATED;
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RESET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        srst_o = cur[1];
        gate_o = cur[0];
        hold_o = cur[1] || (wr_en && req[1]);
    end

endmodule

// File: rtl/sct_irq_reg.sv
module sct_irq_reg
    import sct_regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               wr_en,
    input  alias_op_e          op,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [REG_W-1:0]   q,
    output logic               irq
);

    localparam logic [REG_W-1:0] KEEP = IRQ_STAT_MASK | IRQ_EN_MASK;

    logic [REG_W-1:0] q_r;
    logic [REG_W-1:0] sw_v;
    logic [REG_W-1:0] q_d;

    always_comb begin
        sw_v = q_r;
        if (wr_en) begin
            sw_v = apply_op(op, q_r, wdata);
        end
        // Events are ORed in after the software update, so a same-cycle clear loses
        q_d = (sw_v & KEEP) | event_vec(evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (hold) begin
            q_r <= '0;
        end else begin
            q_r <= q_d;
        end
    end

    assign q   = q_r;
    assign irq = |((q_r >> IRQ_EN_SHIFT) & q_r & IRQ_STAT_MASK);

endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
    import sct_regbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_EVT-1:0]   evt_i,
    output logic                 srst_o,
    output logic                 clk_gate_o,
    output logic                 cts_flow_en_o,
    output logic                 rts_flow_en_o,
    output logic                 rts_o,
    output logic                 rx_en_o,
    output logic                 tx_en_o,
    output logic                 port_en_o,
    output logic [REG_W-1:0]     line_ctrl_o,
    output logic                 irq_o
);

    localparam int IDX_W   = ADDR_W - 4;
    localparam int NUM_GEN = 2;   // port control and line control

    logic [IDX_W-1:0]    idx;
    alias_op_e           op;
    logic [NUM_REGS-1:0] wr_hit;
    logic                hold_s;
    logic                srst_s;
    logic                gate_s;
    logic [REG_W-1:0]    gen_q [NUM_GEN];
    logic [REG_W-1:0]    irq_q;
    logic                irq_s;
    logic                unused_addr_bits;

    assign idx = bus_addr[ADDR_W-1:4];
    assign op  = alias_op_e'(bus_addr[3:2]);
    assign unused_addr_bits = ^bus_addr[1:0];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wr_hit[i] = bus_sel && bus_wr && (idx == IDX_W'(i));
        end
    end

    sct_rst_fsm #(
        .SETTLE_CYC(SETTLE_CYC)
    ) i_rst_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_hit[IDX_CTRL0]),
        .op    (op),
        .wbits (bus_wdata[SRST_BIT:GATE_BIT]),
        .srst_o(srst_s),
        .gate_o(gate_s),
        .hold_o(hold_s)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_reg
        localparam logic [REG_W-1:0] GMASK = (g == 0) ? PORT_MASK : LINE_MASK;
        sct_alias_reg #(
            .MASK   (GMASK),
            .RST_VAL('0)
        ) i_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (hold_s),
            .wr_en(wr_hit[IDX_PORT + g]),
            .op   (op),
            .wdata(bus_wdata),
            .q    (gen_q[g])
        );
    end

    sct_irq_reg i_irq_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold_s),
        .wr_en(wr_hit[IDX_IRQ]),
        .op   (op),
        .wdata(bus_wdata),
        .evt  (evt_i),
        .q    (irq_q),
        .irq  (irq_s)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_W'(IDX_CTRL0): bus_rdata[SRST_BIT:GATE_BIT] = {srst_s, gate_s};
            IDX_W'(IDX_PORT):  bus_rdata = gen_q[0];
            IDX_W'(IDX_LINE):  bus_rdata = gen_q[1];
            IDX_W'(IDX_IRQ):   bus_rdata = irq_q;
            default:           bus_rdata = '0;
        endcase
    end

    assign srst_o        = srst_s;
    assign clk_gate_o    = gate_s;
    assign cts_flow_en_o = gen_q[0][PB_CTSF];
    assign rts_flow_en_o = gen_q[0][PB_RTSF];
    assign rts_o         = gen_q[0][PB_RTS];
    assign rx_en_o       = gen_q[0][PB_RXEN];
    assign tx_en_o       = gen_q[0][PB_TXEN];
    assign port_en_o     = gen_q[0][PB_PEN];
    assign line_ctrl_o   = gen_q[1];
    assign irq_o         = irq_s;

endmodule

// File: rtl/sct_regbank_chk.sv
module sct_regbank_chk
    import sct_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               srst_o,
    input logic               clk_gate_o,
    input logic [REG_W-1:0]   line_ctrl_o,
    input logic               irq_o,
    input logic               hold,
    input logic [REG_W-1:0]   irq_q
);

    localparam logic [ADDR_W-1:0] LINE_SET_ADDR = ADDR_W'(IDX_LINE * 16 + 4);

    // R6: the gate can only open once soft reset reads 0
    a_r6_gate_needs_srst_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate_o) |-> !$past(srst_o));

    // R6: gate stays closed during soft reset
    a_r6_srst_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |-> clk_gate_o);

    // R7: other registers sit at reset while soft reset reads 1
    a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |-> (line_ctrl_o == '0 && !irq_o));

    // R9: an event outside hold always leaves its flag set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i[1]) && !$past(hold)) |-> irq_q[4]);

    // R2: set alias ORs data into the line-control word
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == LINE_SET_ADDR && !hold)
        |=> line_ctrl_o == ($past(line_ctrl_o) | $past(bus_wdata)));

endmodule

bind sct_regbank sct_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt_i      (evt_i),
    .srst_o     (srst_o),
    .clk_gate_o (clk_gate_o),
    .line_ctrl_o(line_ctrl_o),
    .irq_o      (irq_o),
    .hold       (hold_s),
    .irq_q      (irq_q)
);

// File: tb/test_sct_regbank.sv
module test_sct_regbank;

    localparam int ADDR_W     = 8;
    localparam int SETTLE_CYC = 5;

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    // Alias operations on line control (R2, R3), port control mask (R4), ctrl0 low bits (R11)
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h20, 32'h1234_5678, 8'h20, 32'h1234_5678},  // R2 write
        '{1'b1, 8'h24, 32'h0000_00F0, 8'h20, 32'h1234_56F8},  // R2 set
        '{1'b1, 8'h28, 32'h1200_0008, 8'h20, 32'h0034_56F0},  // R2 clear
        '{1'b1, 8'h2C, 32'hFFFF_0000, 8'h20, 32'hFFCB_56F0},  // R2 toggle
        '{1'b0, 8'h00, 32'h0000_0000, 8'h2C, 32'hFFCB_56F0},  // R3 alias read
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'h14, 32'h0000_CB01},  // R4 mask
        '{1'b1, 8'h18, 32'h0000_4100, 8'h10, 32'h0000_8A01},  // R4 clear
        '{1'b1, 8'h1C, 32'h0000_0801, 8'h18, 32'h0000_8200},  // R4 toggle
        '{1'b1, 8'h04, 32'h0000_FFFF, 8'h00, 32'h0000_0000},  // R11
        '{1'b0, 8'h00, 32'h0000_0000, 8'h40, 32'h0000_0000}   // R3 unmapped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_i = '0;
    logic srst_o, clk_gate_o, cts_flow_en_o, rts_flow_en_o, rts_o, rx_en_o, tx_en_o, port_en_o;
    logic [31:0] line_ctrl_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sct_regbank #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) i_sct_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .srst_o(srst_o), .clk_gate_o(clk_gate_o),
        .cts_flow_en_o(cts_flow_en_o), .rts_flow_en_o(rts_flow_en_o), .rts_o(rts_o),
        .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .port_en_o(port_en_o),
        .line_ctrl_o(line_ctrl_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h exp %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_rd("R1 ctrl0", 8'h00, 32'hC000_0000);
        expect_rd("R1 port", 8'h10, 32'h0);
        expect_rd("R1 line", 8'h20, 32'h0);
        expect_rd("R1 irq reg", 8'h30, 32'h0);
        check("R1 srst_o", 32'(srst_o), 32'd1);
        check("R1 clk_gate_o", 32'(clk_gate_o), 32'd1);
        check("R1 irq_o", 32'(irq_o), 32'd0);

        // R6 gate clear ignored during reset
        bus_write(8'h08, 32'h4000_0000);
        expect_rd("R6 gate held", 8'h00, 32'hC000_0000);
        // R7 writes ignored during reset
        bus_write(8'h20, 32'hDEAD_BEEF);
        expect_rd("R7 write ignored", 8'h20, 32'h0);

        // R5 settle period
        bus_write(8'h08, 32'h8000_0000);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            bus_read(8'h00, d);
            if (!d[31]) break;
            n++;
            @(negedge clk);
        end
        check("R5 settle count", 32'(n), 32'(SETTLE_CYC));
        expect_rd("R5 gated state", 8'h00, 32'h4000_0000);
        check("R5 srst_o low", 32'(srst_o), 32'd0);

        // R6 open gate
        bus_write(8'h08, 32'h4000_0000);
        check("R6 gate open", 32'(clk_gate_o), 32'd0);
        expect_rd("R6 ctrl0 run", 8'h00, 32'h0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) bus_write(VECS[v].waddr, VECS[v].wdata);
            bus_read(VECS[v].raddr, d);
            check($sformatf("R%0d vector %0d", (v < 4) ? 2 : (v == 4 || v == 9) ? 3 : (v == 8) ? 11 : 4, v),
                  d, VECS[v].exp);
        end
        // R4 outputs for port value 0x8200
        check("R4 outputs", {26'b0, cts_flow_en_o, rts_flow_en_o, rts_o, rx_en_o, tx_en_o, port_en_o},
              32'b10_0100);

        // R8 / R10 interrupts
        bus_write(8'h30, 32'h0070_0000);
        expect_rd("R8 enables", 8'h30, 32'h0070_0000);
        check("R10 no irq", 32'(irq_o), 32'd0);
        pulse(4'b0010);
        expect_rd("R8 rx flag", 8'h30, 32'h0070_0010);
        check("R10 irq rx", 32'(irq_o), 32'd1);
        pulse(4'b1000);
        pulse(4'b0100);
        expect_rd("R8 rto tx flags", 8'h30, 32'h0070_0070);
        bus_write(8'h38, 32'h0000_0070);
        expect_rd("R9 clear flags", 8'h30, 32'h0070_0000);
        check("R10 irq cleared", 32'(irq_o), 32'd0);
        pulse(4'b0001);
        expect_rd("R8 cts flag", 8'h30, 32'h0070_0002);
        check("R10 cts disabled", 32'(irq_o), 32'd0);
        // R9 same-cycle clear and event
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h0000_0002; evt_i = 4'b0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_i = '0;
        expect_rd("R9 event wins", 8'h30, 32'h0070_0002);
        bus_write(8'h34, 32'h0002_0000);
        expect_rd("R10 cts enabled", 8'h30, 32'h0072_0002);
        check("R10 irq cts", 32'(irq_o), 32'd1);

        // R6 regate keeps registers
        bus_write(8'h04, 32'h4000_0000);
        check("R6 regate", 32'(clk_gate_o), 32'd1);
        expect_rd("R6 ctrl0 gated", 8'h00, 32'h4000_0000);
        expect_rd("R6 line kept", 8'h20, 32'hFFCB_56F0);
        bus_write(8'h08, 32'h4000_0000);
        check("R6 reopen", 32'(clk_gate_o), 32'd0);

        // R7 soft reset from run
        bus_write(8'h04, 32'h8000_0000);
        check("R7 srst_o", 32'(srst_o), 32'd1);
        expect_rd("R7 ctrl0", 8'h00, 32'hC000_0000);
        expect_rd("R7 line", 8'h20, 32'h0);
        expect_rd("R7 port", 8'h10, 32'h0);
        expect_rd("R7 irq reg", 8'h30, 32'h0);
        check("R7 irq_o", 32'(irq_o), 32'd0);
        pulse(4'b1111);
        expect_rd("R7 events ignored", 8'h30, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule